// File: doc/BRIEF.md
# Programmable-Length Serial Shift Engine

This block is a master-mode serial shifter for a microcontroller peripheral bus. A core-clock prescaler of fixed ratio 13 feeds a power-of-two divider chosen by a 3-bit rate code, and the result paces a serial clock. Each frame moves between 1 and 15 bit periods through an 8-bit shift register. The most significant bit goes first, and the bit on the serial output is also the bit that is shifted out. Frames longer than 8 bits push the received bits back out of the register, so a long frame keeps only its last 8 received bits. This lets software drop leading bits it does not want.

Software reaches three bus registers. Address 0 is the data/shift register. Address 1 is the control register: bit 7 is the done flag, bits 6:3 are the frame length and bits 2:0 are the rate code. Address 2 is a write-only pin register whose bit 0 routes the serial output to the output pin. A `start` pulse sets the running state. Hardware clears that state when the last bit ends, and on the same cycle it sets the done flag, which raises `irq` when `irq_mask` is high. The `cpol` and `cpha` inputs pick the idle clock level and the sampling edge.

Top module: `spi_shift_engine`

## Requirements
- R1: One bit period lasts 13 × K core cycles, where K is 1, 2, 4, 8, 16, 32 or 64 for rate codes 0 to 6 and 256 for code 7.
- R2: A `start` pulse while idle raises `running`. It then stays high for exactly length × 13 × K cycles and clears itself.
- R3: The serial output sends the loaded byte MSB first. Bit periods after the eighth send the bits received earlier in the same frame, in order of arrival.
- R4: Received bits enter the register at the least significant end. After a frame, address 0 holds the last 8 bits of the sequence made of the loaded byte followed by the received bits.
- R5: `sck` rests at `cpol` while idle and makes exactly one leading and one trailing edge per bit. With `cpha`=0 the input is sampled on the leading edge and the output changes on the trailing edge. With `cpha`=1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R6: When a frame ends, the done flag (address 1, bit 7) reads 1 and `irq` equals `irq_mask`. The flag is set only at a frame end.
- R7: Writing 0 to bit 7 of address 1 clears the done flag, and writing 1 leaves it unchanged. The length and rate fields read back the values written to them.
- R8: While `running` is high, writes to addresses 0 and 1 and further `start` pulses have no effect.
- R9: After reset, address 1 reads 0x00, `running` and `irq` are low, and `sck` equals `cpol`.
- R10: When bit 0 of address 2 is 1, `sdo_pin` carries the serial data. When it is 0, `sdo_pin` follows `gpio_out`. Reads of address 2 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 data, 1 control, 2 pin) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| start | input | 1 | Frame start request |
| irq_mask | input | 1 | Interrupt enable |
| cpol | input | 1 | Idle clock level |
| cpha | input | 1 | Sampling phase select |
| ser_in | input | 1 | Serial data in |
| gpio_out | input | 1 | Pin value used when serial routing is off |
| sck | output | 1 | Serial clock |
| sdo_pin | output | 1 | Output pin |
| running | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the clock rests at its polarity level while idle, that every frame start comes from a `start` pulse, that the done flag rises only when a frame ends and is always set at that point, and that the configuration fields cannot change during a frame. Only the bench scenarios can show the data behaviour: bit order, the way bits come back out in frames longer than 8, the final register contents, and the period for each rate code. The bench shows these by acting as the serial peer for every polarity, phase and length combination.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int PRE_DIV = 13;
    localparam int SR_W    = 8;
    localparam int LEN_W   = 4;
    localparam int CD_W    = 3;
    localparam int RATIO_W = 9;
    localparam int CFG_W   = LEN_W + CD_W;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CTRL = 2'd1,
        A_PIN  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             done;
        logic [LEN_W-1:0] len;
        logic [CD_W-1:0]  cd;
    } ctrl_t;

    // power-of-two divider ratio; the top code skips ahead to 256
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CD_W-1:0] cd);
        if (cd == '1)
            return RATIO_W'(256);
        return RATIO_W'(1) << cd;
    endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_eng_pkg::*;
#(
    parameter int PRE  = PRE_DIV,
    parameter int CDW  = CD_W,
    parameter int RATW = RATIO_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [CDW-1:0] cd,
    output logic           lead_tick,
    output logic           trail_tick
);
    localparam int PW = $clog2(PRE);
    localparam int RW = RATW - 1;

    logic [PW-1:0]   pre_q;
    logic [RW-1:0]   div_q;
    logic [RATW-1:0] ratio;
    logic [RW-1:0]   div_last;
    logic [RW-1:0]   div_half;
    logic            pre_wrap;

    assign ratio    = ratio_of(cd);
    assign div_last = RW'(ratio - RATW'(1));
    assign div_half = RW'((ratio >> 1) - RATW'(1));
    assign pre_wrap = (pre_q == PW'(PRE - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            div_q <= '0;
        end else begin
            pre_q <= pre_wrap ? '0 : pre_q + PW'(1);
            if (pre_wrap)
                div_q <= (div_q == div_last) ? '0 : div_q + RW'(1);
        end
    end

    // leading edge near mid-period, trailing edge at the end of the period
    always_comb begin
        if (ratio == RATW'(1))
            lead_tick = run && (pre_q == PW'(PRE / 2 - 1));
        else
            lead_tick = run && pre_wrap && (div_q == div_half);
        trail_tick = run && pre_wrap && (div_q == div_last);
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_eng_pkg::*;
#(
    parameter int SRW  = SR_W,
    parameter int LENW = LEN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            lead,
    input  logic            trail,
    input  logic            cpha,
    input  logic            ser_in,
    input  logic            load,
    input  logic [SRW-1:0]  load_val,
    input  logic [LENW-1:0] len,
    output logic [SRW-1:0]  shreg,
    output logic            ser_out,
    output logic            sck_phase,
    output logic            frame_end
);
    logic [SRW-1:0]  sr_q;
    logic [LENW-1:0] idx_q;
    logic            samp_q;
    logic            dout_q;
    logic            phase_q;
    logic            shift_bit;

    assign shift_bit = cpha ? ser_in : samp_q;
    assign frame_end = trail && (idx_q == len - LENW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            samp_q  <= 1'b0;
            dout_q  <= 1'b0;
            phase_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (load)
                sr_q <= load_val;
            else if (trail)
                sr_q <= {sr_q[SRW-2:0], shift_bit};

            if (lead)
                samp_q <= ser_in;
            if (lead && cpha)
                dout_q <= sr_q[SRW-1];

            if (!run) begin
                phase_q <= 1'b0;
                idx_q   <= '0;
            end else begin
                if (lead)
                    phase_q <= 1'b1;
                if (trail) begin
                    phase_q <= 1'b0;
                    idx_q   <= idx_q + LENW'(1);
                end
            end
        end
    end

    assign shreg     = sr_q;
    assign ser_out   = cpha ? dout_q : sr_q[SRW-1];
    assign sck_phase = phase_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       start,
    input  logic       irq_mask,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       ser_in,
    input  logic       gpio_out,
    output logic       sck,
    output logic       sdo_pin,
    output logic       running,
    output logic       irq
);
    ctrl_t            ctrl_q;
    ctrl_t            wr_ctrl_v;
    logic             pin_en_q;
    logic             run_q;
    logic             wr_data;
    logic             wr_ctrl;
    logic             wr_pin;
    logic             lead_tick;
    logic             trail_tick;
    logic             frame_end;
    logic             sck_phase;
    logic             ser_bit;
    logic [SR_W-1:0]  shreg;
    logic             done_flag;
    logic [CFG_W-1:0] cfg_bits;
    reg_addr_e        addr;

    assign addr      = reg_addr_e'(bus_addr);
    assign wr_ctrl_v = ctrl_t'(bus_wdata);
    assign wr_data   = bus_wr && (addr == A_DATA) && !run_q;
    assign wr_ctrl   = bus_wr && (addr == A_CTRL) && !run_q;
    assign wr_pin    = bus_wr && (addr == A_PIN);

    spi_rate_gen #(.PRE(PRE_DIV), .CDW(CD_W), .RATW(RATIO_W)) u_rate (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .cd         (ctrl_q.cd),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick)
    );

    spi_shifter #(.SRW(SR_W), .LENW(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .lead      (lead_tick),
        .trail     (trail_tick),
        .cpha      (cpha),
        .ser_in    (ser_in),
        .load      (wr_data),
        .load_val  (bus_wdata),
        .len       (ctrl_q.len),
        .shreg     (shreg),
        .ser_out   (ser_bit),
        .sck_phase (sck_phase),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            pin_en_q <= 1'b0;
            run_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.len <= wr_ctrl_v.len;
                ctrl_q.cd  <= wr_ctrl_v.cd;
                if (!wr_ctrl_v.done)
                    ctrl_q.done <= 1'b0;
            end
            if (frame_end) begin
                ctrl_q.done <= 1'b1;
                run_q       <= 1'b0;
            end else if (start && !run_q) begin
                run_q <= 1'b1;
            end
            if (wr_pin)
                pin_en_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  bus_rdata = shreg;
            A_CTRL:  bus_rdata = ctrl_q;
            default: bus_rdata = '0;
        endcase
    end

    assign sck       = sck_phase ^ cpol;
    assign sdo_pin   = pin_en_q ? ser_bit : gpio_out;
    assign running   = run_q;
    assign irq       = ctrl_q.done & irq_mask;
    assign done_flag = ctrl_q.done;
    assign cfg_bits  = {ctrl_q.len, ctrl_q.cd};

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
    parameter int CFGW = spi_eng_pkg::CFG_W
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            running,
    input logic            sck,
    input logic            cpol,
    input logic            done_flag,
    input logic [CFGW-1:0] cfg_bits
);
    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> (sck == cpol));

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

    // R6
    done_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> done_flag);

    // R6
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $fell(running));

    // R8
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(cfg_bits));

endmodule

bind spi_shift_engine spi_shift_engine_chk #(.CFGW(spi_eng_pkg::CFG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .running   (running),
    .sck       (sck),
    .cpol      (cpol),
    .done_flag (done_flag),
    .cfg_bits  (cfg_bits)
);

// File: tb/spi_shift_engine_test.sv
`timescale 1ns/1ps
module spi_shift_engine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       start = 1'b0;
    logic       irq_mask = 1'b1;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       ser_in = 1'b0;
    logic       gpio_out = 1'b0;
    logic       sck;
    logic       sdo_pin;
    logic       running;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_shift_engine uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start),
        .irq_mask(irq_mask), .cpol(cpol), .cpha(cpha), .ser_in(ser_in),
        .gpio_out(gpio_out), .sck(sck), .sdo_pin(sdo_pin),
        .running(running), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int ratio(input int cd);
        return (cd == 7) ? 256 : (1 << cd);
    endfunction

    // k-th bit of the stream: loaded byte MSB first, then the received bits
    function automatic logic sbit(input logic [7:0] tx, input logic [15:0] rx, input int k);
        return (k < 8) ? tx[7-k] : rx[k-8];
    endfunction

    task automatic run_frame(input logic pol, input logic ph, input int len, input int cd,
                             input logic [7:0] tx, input logic [15:0] rxb, input bit meddle);
        int busy, nlead, ntrail, oi, t1, t2, nper;
        logic prev;
        logic [14:0] got, exp_out;
        logic [7:0] rdv, exp_reg;
        cpol = pol; cpha = ph;
        wr(2'd1, {1'b0, 4'(len), 3'(cd)});
        wr(2'd0, tx);
        ser_in = rxb[0];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        busy = 0; nlead = 0; ntrail = 0; oi = 0; t1 = 0; t2 = 0;
        got = '0; prev = sck;
        while (running) begin
            busy++;
            if (meddle) begin
                case (busy)
                    20: begin bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h7F; end
                    21: begin bus_addr = 2'd0; bus_wdata = 8'h3C; end
                    22: begin bus_wr = 1'b0; start = 1'b1; end
                    23: start = 1'b0;
                    default: ;
                endcase
            end
            @(negedge clk);
            if (sck !== prev) begin
                if (prev == pol) begin
                    nlead++;
                    if (nlead == 1) t1 = busy;
                    if (nlead == 2) t2 = busy;
                    if (!ph) begin got[oi] = sdo_pin; oi++; end
                    else ser_in = rxb[nlead-1];
                end else begin
                    ntrail++;
                    if (!ph) ser_in = rxb[ntrail];
                    else begin got[oi] = sdo_pin; oi++; end
                end
                prev = sck;
            end
        end
        nper = 13 * ratio(cd);
        check("R2 busy cycles", busy, len * nper);
        check("R5 leading edges per frame", nlead, len);
        check("R5 trailing edges per frame", ntrail, len);
        if (len >= 2) check("R1 bit period", t2 - t1, nper);
        exp_out = '0;
        for (int i = 0; i < len; i++) exp_out[i] = sbit(tx, rxb, i);
        check("R3 serial output bits", got, exp_out);
        for (int b = 0; b < 8; b++) exp_reg[b] = sbit(tx, rxb, len + 7 - b);
        rd(2'd0, rdv);
        check(meddle ? "R8 data write ignored / R4 data" : "R4 received data", rdv, exp_reg);
        rd(2'd1, rdv);
        check(meddle ? "R8 control write ignored" : "R6 done flag and fields", rdv,
              {1'b1, 4'(len), 3'(cd)});
        check("R6 irq follows mask", irq, irq_mask);
        check("R5 idle clock level", sck, pol);
        wr(2'd1, {1'b1, 4'(len), 3'(cd)});
        rd(2'd1, rdv);
        check("R7 writing 1 keeps flag", rdv[7], 1'b1);
        wr(2'd1, {1'b0, 4'(len), 3'(cd)});
        rd(2'd1, rdv);
        check("R7 writing 0 clears flag", rdv[7], 1'b0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd1, v);
        check("R9 control reset value", v, 8'h00);
        check("R9 running after reset", running, 1'b0);
        check("R9 irq after reset", irq, 1'b0);
        check("R9 sck after reset", sck, cpol);

        gpio_out = 1'b1; #1;
        check("R10 pin follows gpio high", sdo_pin, 1'b1);
        gpio_out = 1'b0; #1;
        check("R10 pin follows gpio low", sdo_pin, 1'b0);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h80);
        #1 check("R10 pin carries serial msb 1", sdo_pin, 1'b1);
        gpio_out = 1'b1;
        wr(2'd0, 8'h7F);
        #1 check("R10 pin carries serial msb 0", sdo_pin, 1'b0);
        rd(2'd2, v);
        check("R10 pin register reads zero", v, 8'h00);

        wr(2'd1, 8'hAB);
        rd(2'd1, v);
        check("R7 flag not settable, fields read back", v, 8'h2B);
        cpol = 1'b1; #1;
        check("R5 idle level follows cpol", sck, 1'b1);

        for (int p = 0; p < 2; p++)
            for (int h = 0; h < 2; h++)
                for (int l = 1; l < 16; l++)
                    run_frame(p[0], h[0], l, 0, 8'(8'h96 + l * 29),
                              16'(16'hC35A ^ (l * 4369) ^ (p * 255) ^ (h * 3855)), 1'b0);

        irq_mask = 1'b0;
        for (int c = 0; c < 8; c++)
            run_frame(1'b0, 1'b0, 2, c, 8'(8'hB1 ^ c), 16'(c + 1), 1'b0);
        irq_mask = 1'b1;

        run_frame(1'b1, 1'b1, 12, 0, 8'h5E, 16'hA6F1, 1'b1);
        run_frame(1'b0, 1'b1, 9, 1, 8'hC3, 16'h5A5A, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule